// File: doc/BRIEF.md
# Scattered-Window Cartridge Bank Mapper

This block sits on the program side of a cartridge and serves an 8-bit CPU that has a 16-bit address bus and separate read and write strobes. For every access it decides whether external program ROM, the 8 KB work RAM, or neither device should answer. It drives the device addresses and chip selects for that choice, plus a write enable for the RAM. The ROM is 128 KB and is built from 4 KB pages. The top 32 KB of the ROM is always visible in the upper half of the CPU map. Two switchable pages appear in small, oddly placed windows.

The two bank selectors are loaded from the CPU address lines, not from the data bus. A write anywhere in the first selector range sets the page number for the low switchable window. A write anywhere in the second selector range sets the page number for the split switchable window. The RAM is not placed in one block. It is spread across three windows, and two of them cut holes into the fixed ROM region. One switchable page is split between two windows, so one quarter of it appears below 0x7000 and the remaining three quarters appear at 0xC000.

Top module: `scatter_bank_mapper`

## Requirements
- R1: A write (cpu_wr=1) at any address in 0x8000–0x8FFF loads the low-page selector S0 with cpu_addr[2:0] on that clock edge. No data value takes part in the load.
- R2: A write at any address in 0x9000–0x9FFF loads the split-page selector S1 with cpu_addr[3:0] on that clock edge.
- R3: While rst_n is low, S0 and S1 are forced to all ones (S0=7, S1=15). They hold these values until the first selector write.
- R4: A read in 0x8000–0xFFFF that falls outside the windows of R5 and R8 sets rom_cs=1 and rom_addr = (24 + cpu_addr[14:12])·4096 + cpu_addr[11:0]. This includes reads in the selector ranges.
- R5: A read or a write in a RAM window sets ram_cs=1, and ram_we equals cpu_wr. The RAM windows map as follows: 0x6000–0x6BFF maps to offset addr−0x6000. 0xB800–0xBFFF maps to 0x0C00 + (addr−0xB800). 0xCC00–0xD7FF maps to 0x1400 + (addr−0xCC00). Data written through one window reads back only at the same RAM offset.
- R6: A read in 0x7000–0x7FFF sets rom_cs=1 and rom_addr = S0·4096 + (addr−0x7000).
- R7: A read in 0x6C00–0x6FFF sets rom_cs=1 and rom_addr = (8+S1)·4096 + (addr−0x6C00).
- R8: A read in 0xC000–0xCBFF sets rom_cs=1 and rom_addr = (8+S1)·4096 + 0x400 + (addr−0xC000).
- R9: The block selects no device in these cases: writes to ROM windows, writes to 0xA000–0xFFFF outside the RAM windows, and any access below 0x6000. In each case rom_cs, ram_cs and ram_we stay 0. A write outside the selector ranges leaves S0 and S1 unchanged. When a select is low, its address output is 0.
- R10: rom_cs and ram_cs are never high together. With neither strobe asserted, both are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the selector registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| rom_addr | output | 17 | ROM byte address |
| rom_cs | output | 1 | ROM chip select (reads only) |
| ram_addr | output | 13 | Work RAM byte address |
| ram_cs | output | 1 | Work RAM chip select |
| ram_we | output | 1 | Work RAM write enable |

## Verification
The assertions assume that the CPU never raises cpu_rd and cpu_wr in the same cycle. They also assume that the address is stable for the whole cycle in which a strobe is high. Under these conditions the exclusive selects and the write-only RAM enable are meaningful. The bench changes address and strobes only on the falling clock edge, asserts at most one strobe at a time, and checks the decoded outputs within that half cycle. The selector-hold property further assumes that a write strobe outside the selector ranges never changes a bank value. The bench tests this by writing into ROM windows and unmapped space and then reading the switchable windows again.

// File: rtl/scatter_map_pkg.sv
package scatter_map_pkg;

   typedef enum logic [2:0] {
      WIN_NONE,
      WIN_RAM_A,
      WIN_RAM_B,
      WIN_RAM_C,
      WIN_ROM_P0,
      WIN_ROM_P1A,
      WIN_ROM_P1B,
      WIN_ROM_FIX
   } win_e;

   // CPU-side window bounds
   localparam logic [15:0] RAM_A_LO = 16'h6000;
   localparam logic [15:0] RAM_A_HI = 16'h6BFF;
   localparam logic [15:0] P1A_LO   = 16'h6C00;
   localparam logic [15:0] P1A_HI   = 16'h6FFF;
   localparam logic [15:0] P0_LO    = 16'h7000;
   localparam logic [15:0] P0_HI    = 16'h7FFF;
   localparam logic [15:0] RAM_B_LO = 16'hB800;
   localparam logic [15:0] RAM_B_HI = 16'hBFFF;
   localparam logic [15:0] P1B_LO   = 16'hC000;
   localparam logic [15:0] P1B_HI   = 16'hCBFF;
   localparam logic [15:0] RAM_C_LO = 16'hCC00;
   localparam logic [15:0] RAM_C_HI = 16'hD7FF;
   localparam logic [15:0] FIX_LO   = 16'h8000;

   // selector load ranges
   localparam logic [15:0] SEL0_LO  = 16'h8000;
   localparam logic [15:0] SEL0_HI  = 16'h8FFF;
   localparam logic [15:0] SEL1_LO  = 16'h9000;
   localparam logic [15:0] SEL1_HI  = 16'h9FFF;

   // device-side destinations
   localparam int unsigned RAM_B_DST = 'h0C00;
   localparam int unsigned RAM_C_DST = 'h1400;
   localparam int unsigned P1B_DST   = 'h0400;

endpackage

// File: rtl/bank_addr_latch.sv
module bank_addr_latch #(
   parameter int unsigned          W      = 3,
   parameter int unsigned          CPU_AW = 16,
   parameter logic [CPU_AW-1:0]    LO     = '0,
   parameter logic [CPU_AW-1:0]    HI     = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic              cpu_wr,
   output logic [W-1:0]      bank_q
);

   if (W > CPU_AW) begin : g_bad_width
      $error("bank_addr_latch: W exceeds address width");
   end

   logic hit;
   assign hit = cpu_wr && (cpu_addr >= LO) && (cpu_addr <= HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   bank_q <= '1;
      else if (hit) bank_q <= cpu_addr[W-1:0];
   end

   // R1 and R2: load from the address lines on the write edge
   assert_bank_load_R1_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> bank_q == $past(cpu_addr[W-1:0]));

   // R9: no load outside the range
   assert_bank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(bank_q));

endmodule

// File: rtl/window_decode.sv
module window_decode
   import scatter_map_pkg::*;
(
   input  logic [15:0] cpu_addr,
   output win_e        win
);

   function automatic logic in_rng(input logic [15:0] a, input logic [15:0] lo,
                                   input logic [15:0] hi);
      return (a >= lo) && (a <= hi);
   endfunction

   // The RAM and split-page windows take priority over the fixed region
   always_comb begin
      win = WIN_NONE;
      if      (in_rng(cpu_addr, RAM_A_LO, RAM_A_HI)) win = WIN_RAM_A;
      else if (in_rng(cpu_addr, P1A_LO,   P1A_HI))   win = WIN_ROM_P1A;
      else if (in_rng(cpu_addr, P0_LO,    P0_HI))    win = WIN_ROM_P0;
      else if (in_rng(cpu_addr, RAM_B_LO, RAM_B_HI)) win = WIN_RAM_B;
      else if (in_rng(cpu_addr, P1B_LO,   P1B_HI))   win = WIN_ROM_P1B;
      else if (in_rng(cpu_addr, RAM_C_LO, RAM_C_HI)) win = WIN_RAM_C;
      else if (cpu_addr >= FIX_LO)                   win = WIN_ROM_FIX;
   end

endmodule

// File: rtl/address_former.sv
module address_former
   import scatter_map_pkg::*;
#(
   parameter int unsigned ROM_AW     = 17,
   parameter int unsigned RAM_AW     = 13,
   parameter int unsigned PAGE_AW    = 12,
   parameter int unsigned SEL0_W     = 3,
   parameter int unsigned SEL1_W     = 4,
   parameter int unsigned P1_BASE    = 8,
   parameter int unsigned FIXED_BASE = 24,
   parameter bit          ZERO_IDLE  = 1'b1
) (
   input  logic [15:0]       cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  win_e              win,
   input  logic [SEL0_W-1:0] sel0,
   input  logic [SEL1_W-1:0] sel1,
   output logic [ROM_AW-1:0] rom_addr,
   output logic              rom_cs,
   output logic [RAM_AW-1:0] ram_addr,
   output logic              ram_cs,
   output logic              ram_we
);

   localparam int unsigned PG_W    = ROM_AW - PAGE_AW;
   localparam int unsigned FIX_SEL = 3;

   logic                is_ram, is_rom;
   logic [PG_W-1:0]     page;
   logic [PAGE_AW-1:0]  off;
   logic [RAM_AW-1:0]   ram_raw;
   logic [ROM_AW-1:0]   rom_raw;

   assign is_ram = (win == WIN_RAM_A) || (win == WIN_RAM_B) || (win == WIN_RAM_C);
   assign is_rom = (win == WIN_ROM_P0) || (win == WIN_ROM_P1A) ||
                   (win == WIN_ROM_P1B) || (win == WIN_ROM_FIX);

   assign rom_cs = cpu_rd && is_rom;
   assign ram_cs = (cpu_rd || cpu_wr) && is_ram;
   assign ram_we = cpu_wr && is_ram;

   always_comb begin
      case (win)
         WIN_RAM_B: ram_raw = RAM_AW'(cpu_addr - RAM_B_LO) + RAM_AW'(RAM_B_DST);
         WIN_RAM_C: ram_raw = RAM_AW'(cpu_addr - RAM_C_LO) + RAM_AW'(RAM_C_DST);
         default:   ram_raw = RAM_AW'(cpu_addr - RAM_A_LO);
      endcase
   end

   always_comb begin
      case (win)
         WIN_ROM_P0: begin
            page = PG_W'(sel0);
            off  = PAGE_AW'(cpu_addr - P0_LO);
         end
         WIN_ROM_P1A: begin
            page = PG_W'(P1_BASE) + PG_W'(sel1);
            off  = PAGE_AW'(cpu_addr - P1A_LO);
         end
         WIN_ROM_P1B: begin
            page = PG_W'(P1_BASE) + PG_W'(sel1);
            off  = PAGE_AW'(cpu_addr - P1B_LO) + PAGE_AW'(P1B_DST);
         end
         default: begin
            page = PG_W'(FIXED_BASE) + PG_W'(cpu_addr[PAGE_AW +: FIX_SEL]);
            off  = cpu_addr[PAGE_AW-1:0];
         end
      endcase
   end

   assign rom_raw = {page, off};

   if (ZERO_IDLE) begin : g_zero_idle
      assign rom_addr = rom_cs ? rom_raw : '0;
      assign ram_addr = ram_cs ? ram_raw : '0;
   end else begin : g_pass_idle
      assign rom_addr = rom_raw;
      assign ram_addr = ram_raw;
   end

endmodule

// File: rtl/scatter_bank_mapper.sv
module scatter_bank_mapper
   import scatter_map_pkg::*;
#(
   parameter int unsigned CPU_AW     = 16,
   parameter int unsigned ROM_AW     = 17,
   parameter int unsigned RAM_AW     = 13,
   parameter int unsigned PAGE_AW    = 12,
   parameter int unsigned SEL0_W     = 3,
   parameter int unsigned SEL1_W     = 4,
   parameter int unsigned P1_BASE    = 8,
   parameter int unsigned FIXED_BASE = 24,
   parameter bit          ZERO_IDLE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   output logic [16:0]       rom_addr,
   output logic              rom_cs,
   output logic [12:0]       ram_addr,
   output logic              ram_cs,
   output logic              ram_we
);

   localparam int unsigned PAGES = 1 << (ROM_AW - PAGE_AW);

   if (CPU_AW != 16 || PAGE_AW != 12) begin : g_bad_geometry
      $error("scatter_bank_mapper: windows assume 16-bit CPU and 4 KB pages");
   end
   if (ROM_AW != 17 || RAM_AW != 13) begin : g_bad_ports
      $error("scatter_bank_mapper: port widths fixed at 17/13 bits");
   end
   if (FIXED_BASE + 8 > PAGES || P1_BASE + (1 << SEL1_W) > PAGES ||
       (1 << SEL0_W) > PAGES) begin : g_bad_pages
      $error("scatter_bank_mapper: page numbers exceed ROM size");
   end

   logic [SEL0_W-1:0] sel0;
   logic [SEL1_W-1:0] sel1;
   win_e              win;

   bank_addr_latch #(.W(SEL0_W), .CPU_AW(16), .LO(SEL0_LO), .HI(SEL0_HI)) sel0_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .bank_q(sel0));

   bank_addr_latch #(.W(SEL1_W), .CPU_AW(16), .LO(SEL1_LO), .HI(SEL1_HI)) sel1_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .bank_q(sel1));

   window_decode dec_i (.cpu_addr(cpu_addr), .win(win));

   address_former #(
      .ROM_AW(ROM_AW), .RAM_AW(RAM_AW), .PAGE_AW(PAGE_AW), .SEL0_W(SEL0_W),
      .SEL1_W(SEL1_W), .P1_BASE(P1_BASE), .FIXED_BASE(FIXED_BASE), .ZERO_IDLE(ZERO_IDLE)
   ) form_i (
      .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .win(win),
      .sel0(sel0), .sel1(sel1), .rom_addr(rom_addr), .rom_cs(rom_cs),
      .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we));

   assert_cs_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(rom_cs && ram_cs));

   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_rd || cpu_wr) |-> !rom_cs && !ram_cs);

   assert_rom_readonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rom_cs |-> cpu_rd && !cpu_wr);

   assert_low_space_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr < 16'h6000) |-> !rom_cs && !ram_cs);

   assert_we_in_ram_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ram_cs && cpu_wr);

   assert_fixed_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && cpu_addr >= 16'hE000) |-> rom_cs && rom_addr[16:15] == 2'b11);

endmodule

// File: tb/scatter_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module scatter_bank_mapper_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [7:0]  wdata = '0;
   logic [16:0] rom_addr;
   logic        rom_cs;
   logic [12:0] ram_addr;
   logic        ram_cs;
   logic        ram_we;

   int checks = 0;
   int errors = 0;
   logic [2:0] b0 = 3'd7;
   logic [3:0] b1 = 4'd15;
   logic [7:0] ram_mem [0:8191];

   always #2.5 clk = ~clk;

   scatter_bank_mapper dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .rom_addr(rom_addr), .rom_cs(rom_cs), .ram_addr(ram_addr), .ram_cs(ram_cs),
      .ram_we(ram_we));

   // external RAM model
   always @(posedge clk) if (ram_we) ram_mem[ram_addr] <= wdata;

   function automatic logic [7:0] rom_byte(input logic [16:0] a);
      return a[7:0] ^ a[15:8] ^ {7'd0, a[16]};
   endfunction

   function automatic logic [7:0] cpu_rdata();
      if (rom_cs) return rom_byte(rom_addr);
      if (ram_cs) return ram_mem[ram_addr];
      return 8'h00;
   endfunction

   typedef struct packed {
      logic [15:0] a;
      logic [1:0]  sel;   // 0 none, 1 ROM, 2 RAM
      logic [16:0] dev;
   } vec_t;

   // read map under reset selectors (S0=7, S1=15)
   localparam vec_t VEC [0:19] = '{
      '{16'h5FFF, 2'd0, 17'h00000}, '{16'h6000, 2'd2, 17'h00000},
      '{16'h6BFF, 2'd2, 17'h00BFF}, '{16'h6C00, 2'd1, 17'h17000},
      '{16'h6FFF, 2'd1, 17'h173FF}, '{16'h7000, 2'd1, 17'h07000},
      '{16'h7FFF, 2'd1, 17'h07FFF}, '{16'h8000, 2'd1, 17'h18000},
      '{16'h8FFF, 2'd1, 17'h18FFF}, '{16'h9000, 2'd1, 17'h19000},
      '{16'hB7FF, 2'd1, 17'h1B7FF}, '{16'hB800, 2'd2, 17'h00C00},
      '{16'hBFFF, 2'd2, 17'h013FF}, '{16'hC000, 2'd1, 17'h17400},
      '{16'hCBFF, 2'd1, 17'h17FFF}, '{16'hCC00, 2'd2, 17'h01400},
      '{16'hD7FF, 2'd2, 17'h01FFF}, '{16'hD800, 2'd1, 17'h1D800},
      '{16'hFFFF, 2'd1, 17'h1FFFF}, '{16'h0000, 2'd0, 17'h00000}
   };

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s addr=%h actual=%h expected=%h", req, what, cpu_addr, act, exp);
      end
   endtask

   task automatic ref_check(input string req);
      int ai;
      logic rcs, mcs, mwe;
      int ra, ma;
      ai = int'(cpu_addr);
      rcs = 0; mcs = 0; mwe = 0; ra = 0; ma = 0;
      if (ai >= 'h6000 && ai <= 'h6BFF)      begin mcs = 1; ma = ai - 'h6000; end
      else if (ai >= 'hB800 && ai <= 'hBFFF) begin mcs = 1; ma = ai - 'hB800 + 'hC00; end
      else if (ai >= 'hCC00 && ai <= 'hD7FF) begin mcs = 1; ma = ai - 'hCC00 + 'h1400; end
      else if (ai >= 'h6C00 && ai <= 'h6FFF) begin rcs = 1; ra = (8 + int'(b1)) * 4096 + ai - 'h6C00; end
      else if (ai >= 'h7000 && ai <= 'h7FFF) begin rcs = 1; ra = int'(b0) * 4096 + ai - 'h7000; end
      else if (ai >= 'hC000 && ai <= 'hCBFF) begin rcs = 1; ra = (8 + int'(b1)) * 4096 + 'h400 + ai - 'hC000; end
      else if (ai >= 'h8000)                 begin rcs = 1; ra = (24 + ((ai >> 12) & 7)) * 4096 + (ai & 'hFFF); end
      if (mcs) begin mcs = cpu_rd | cpu_wr; mwe = cpu_wr; if (!mcs) ma = 0; end
      if (rcs) begin rcs = cpu_rd; if (!rcs) ra = 0; end
      chk(req, "rom_cs",   32'(rom_cs),   32'(rcs));
      chk(req, "rom_addr", 32'(rom_addr), ra);
      chk(req, "ram_cs",   32'(ram_cs),   32'(mcs));
      chk(req, "ram_addr", 32'(ram_addr), ma);
      chk(req, "ram_we",   32'(ram_we),   32'(mwe));
   endtask

   task automatic rd_at(input logic [15:0] a);
      @(negedge clk);
      cpu_wr = 0; cpu_rd = 1; cpu_addr = a;
      #1;
   endtask

   task automatic wr_at(input logic [15:0] a, input logic [7:0] d, input string req);
      @(negedge clk);
      cpu_rd = 0; cpu_wr = 1; cpu_addr = a; wdata = d;
      #1;
      ref_check(req);
      @(posedge clk);
      if (a >= 16'h8000 && a <= 16'h8FFF) b0 = a[2:0];
      if (a >= 16'h9000 && a <= 16'h9FFF) b1 = a[3:0];
      #1;
      cpu_wr = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8192; i++) ram_mem[i] = 8'h00;
      // reset state: no strobe, nothing selected (R10)
      #12;
      chk("R10", "rom_cs in reset", 32'(rom_cs), 0);
      chk("R10", "ram_cs in reset", 32'(ram_cs), 0);
      @(negedge clk); rst_n = 1;

      // table walk under reset selector values (R3 and the map R4..R8)
      for (int i = 0; i < 20; i++) begin
         rd_at(VEC[i].a);
         chk("R3", "rom_cs",  32'(rom_cs), 32'(VEC[i].sel == 2'd1));
         chk("R3", "ram_cs",  32'(ram_cs), 32'(VEC[i].sel == 2'd2));
         if (VEC[i].sel == 2'd1) chk("R3", "rom_addr", 32'(rom_addr), 32'(VEC[i].dev));
         if (VEC[i].sel == 2'd2) chk("R3", "ram_addr", 32'(ram_addr), 32'(VEC[i].dev));
      end

      // R1: selector from address bits, data value irrelevant
      wr_at(16'h8005, 8'hFF, "R1");
      rd_at(16'h7123); chk("R1", "rom_addr", 32'(rom_addr), 32'h05123);
      wr_at(16'h8005, 8'h00, "R1");
      rd_at(16'h7123); chk("R1", "rom_addr data-independent", 32'(rom_addr), 32'h05123);
      wr_at(16'h8FFA, 8'h5A, "R1");
      rd_at(16'h7000); chk("R1", "rom_addr", 32'(rom_addr), 32'h02000);
      // R2
      wr_at(16'h9003, 8'hAA, "R2");
      rd_at(16'h6C10); chk("R7", "rom_addr", 32'(rom_addr), 32'h0B010);
      rd_at(16'hC000); chk("R8", "rom_addr", 32'(rom_addr), 32'h0B400);
      wr_at(16'h9FF0, 8'h11, "R2");
      rd_at(16'hCBFF); chk("R8", "rom_addr", 32'(rom_addr), 32'h08FFF);
      rd_at(16'h8FFF); chk("R4", "rom_addr in selector range", 32'(rom_addr), 32'h18FFF);

      // boundary sweep with several selector settings
      foreach (VEC[i]) begin rd_at(VEC[i].a); ref_check("R4_R6_R7_R8 sweep"); end
      wr_at(16'h8006, 8'h00, "R1"); wr_at(16'h9A09, 8'h00, "R2");
      foreach (VEC[i]) begin rd_at(VEC[i].a); ref_check("R6 R7 R8 sweep"); end
      wr_at(16'h8000, 8'h00, "R1"); wr_at(16'h900C, 8'h00, "R2");
      foreach (VEC[i]) begin rd_at(VEC[i].a); ref_check("R5 sweep"); end

      // R9: ignored writes select nothing and leave selectors alone
      wr_at(16'h7000, 8'h33, "R9");
      chk("R9", "rom_cs on ROM write", 32'(rom_cs), 0);
      wr_at(16'h6C00, 8'h33, "R9");
      wr_at(16'hC400, 8'h33, "R9");
      wr_at(16'hA123, 8'h33, "R9");
      wr_at(16'h1234, 8'h33, "R9");
      rd_at(16'h7000); chk("R9", "S0 unchanged", 32'(rom_addr), 32'h00000);
      rd_at(16'h6C00); chk("R9", "S1 unchanged", 32'(rom_addr), 32'h14000);
      rd_at(16'h4000); chk("R9", "rdata low space", 32'(cpu_rdata()), 0);

      // R5: write through one window, read back only at the matching offset
      wr_at(16'hB800, 8'hA5, "R5");
      rd_at(16'hB800); chk("R5", "readback B800", 32'(cpu_rdata()), 32'hA5);
      rd_at(16'hB801); chk("R5", "neighbour B801", 32'(cpu_rdata()), 32'h00);
      rd_at(16'h6000); chk("R5", "other window 6000", 32'(cpu_rdata()), 32'h00);
      rd_at(16'hCC00); chk("R5", "other window CC00", 32'(cpu_rdata()), 32'h00);
      wr_at(16'hD7FF, 8'h5A, "R5");
      rd_at(16'h6BFF); chk("R5", "6BFF untouched", 32'(cpu_rdata()), 32'h00);
      rd_at(16'hD7FF); chk("R5", "readback D7FF", 32'(cpu_rdata()), 32'h5A);
      wr_at(16'h6BFF, 8'h3C, "R5");
      rd_at(16'h6BFF); chk("R5", "readback 6BFF", 32'(cpu_rdata()), 32'h3C);
      rd_at(16'hBFFF); chk("R5", "BFFF untouched", 32'(cpu_rdata()), 32'h00);
      rd_at(16'hB800); chk("R5", "B800 kept", 32'(cpu_rdata()), 32'hA5);

      // write-select sweep outside the selector ranges (R5 R9 R10)
      foreach (VEC[i])
         if (!(VEC[i].a >= 16'h8000 && VEC[i].a <= 16'h9FFF)) wr_at(VEC[i].a, 8'h00, "R10");

      // no strobe: nothing selected
      @(negedge clk); cpu_rd = 0; cpu_wr = 0; cpu_addr = 16'hB900; #1;
      chk("R10", "ram_cs idle", 32'(ram_cs), 0);
      chk("R10", "rom_cs idle", 32'(rom_cs), 0);

      // R3: reset returns selectors to all ones
      @(negedge clk); rst_n = 0; b0 = 3'd7; b1 = 4'd15;
      @(negedge clk); rst_n = 1;
      rd_at(16'h7ABC); chk("R3", "S0 after reset", 32'(rom_addr), 32'h07ABC);
      rd_at(16'hC123); chk("R3", "S1 after reset", 32'(rom_addr), 32'h17523);

      @(negedge clk); cpu_rd = 0;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule